// File: doc/BRIEF.md
# Cascaded Voltage/Current Loop Compensator

This block closes both feedback loops of an average-current-mode power stage in fixed point. Once per switching period a trigger presents three values: the output-voltage sample, the inductor-current sample and the voltage setpoint. The outer stage turns the voltage error into a current setpoint. The inner stage turns the difference between that setpoint and the current sample into a duty-cycle word for the modulator.

Each stage is a two-pole, two-zero difference equation. It keeps its last two errors and its last two outputs. Both stages share one multiply-accumulate datapath, which works through the ten products over a fixed number of cycles. Each stage result is floored by a fractional shift and then limited to that stage's own bounds. Only the limited value is written back into the output history, so neither integrator winds up.

The block has four control inputs. A clear input wipes all history. A preload input seeds the inner stage's output history so that a restart carries on from a known duty. An enable input gates execution. A proportional-only mode replaces both compensators with a plain gain, for measuring the plant's frequency response. All coefficients, limits and widths are parameters.

Top module: `avg_cm_loop`

## Requirements
- R1: After reset `duty` and `cur_ref` are 0 and `done` is low.
- R2: A trigger is accepted when the block is idle, `en` is high, and `clr` and `pre` are low. Exactly 6 clock edges after the accepting edge, `cur_ref` becomes the outer result. That result is clamp(floor((B0_V*e0 + B1_V*e1 + B2_V*e2 + A1_V*u1 + A2_V*u2) / 2^FRAC), VMIN, VMAX). Here e0 = vref - vsamp, e1 and e2 are the two previous outer errors, and u1 and u2 are the two previous outer outputs.
- R3: Exactly 12 clock edges after the accepting edge, `duty` takes the inner result and `done` is high for exactly one cycle. The inner result uses the same equation with the *_I coefficients and the limits IMIN and IMAX. Its error is the new `cur_ref` minus `isamp`.
- R4: Each stage result is held within its own limits: `cur_ref` within [VMIN, VMAX] and `duty` within [IMIN, IMAX].
- R5: The output history of each stage stores the clamped result, not the unclamped sum.
- R6: A trigger that arrives while a computation is running, or while `en` is low, is ignored and produces no `done`.
- R7: If `en` is low at a clock edge, any computation in progress is abandoned without a `done`, and `duty` and `cur_ref` hold their values.
- R8: `clr` has priority over every other input. It abandons any running computation and zeroes all error and output histories of both stages, so `duty` and `cur_ref` read 0 on the next cycle.
- R9: `pre` (when `clr` is low) abandons any running computation and writes `pre_val` into both inner output-history taps, so `duty` equals `pre_val` on the next cycle. The outer stage's history is left unchanged.
- R10: When `prop_mode` is high at the accepting edge, each stage result becomes clamp(floor(KP*e0 / 2^FRAC)), using KP_V for the outer stage and KP_I for the inner stage. The error and output histories still shift as in normal operation.
- R11: `duty` changes only with a `done` pulse, a clear or a preload.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Loop execution enable |
| trig | input | 1 | Start one control update |
| clr | input | 1 | Zero all histories |
| pre | input | 1 | Load `pre_val` into the inner output history |
| pre_val | input | DW | Duty value for preload |
| prop_mode | input | 1 | Proportional-only test mode |
| vref | input | DW | Output-voltage setpoint (unsigned) |
| vsamp | input | DW | Output-voltage sample (unsigned) |
| isamp | input | DW | Inductor-current sample (unsigned) |
| done | output | 1 | One-cycle strobe: new duty valid |
| duty | output | DW | Duty-cycle command |
| cur_ref | output | DW | Current setpoint produced by the outer stage |

## Verification
Several properties are checked on every cycle. The result strobe is one cycle wide. Both outputs stay inside their bounds whenever they change. `duty` holds between updates. A low enable suppresses the strobe. Clear and preload produce their stated output values on the following cycle.

The arithmetic is left to the bench's scenarios. These cover the exact compensator values, the anti-windup history, the arrival cycle of each stage's result, and the dropping of triggers while busy or disabled. They also cover the state left behind by an aborted computation and the proportional-mode results. A behavioural model runs the difference equations in integers alongside the design.

// File: rtl/avg_cm_pkg.sv
package avg_cm_pkg;
  localparam int TAPS = 5;

  function automatic logic signed [63:0] sat64(input logic signed [63:0] x,
                                               input longint lo, input longint hi);
    logic signed [63:0] r;
    if (x > hi)      r = hi;
    else if (x < lo) r = lo;
    else             r = x;
    return r;
  endfunction
endpackage

// File: rtl/acm_seq.sv
module acm_seq
  import avg_cm_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       en,
  input  logic       trig,
  input  logic       clr,
  input  logic       pre,
  output logic       accept,
  output logic       abort,
  output logic       step,
  output logic       commit,
  output logic       stage,
  output logic [2:0] tap,
  output logic       done
);
  logic       busy_q, busy_d;
  logic       stage_q, stage_d;
  logic [2:0] tap_q, tap_d;
  logic       done_q, done_d;

  always_comb begin
    accept = !busy_q && en && trig && !clr && !pre;
    abort  = busy_q && (clr || pre || !en);
    step   = busy_q && !abort && (tap_q < 3'(TAPS));
    commit = busy_q && !abort && (tap_q == 3'(TAPS));
    busy_d  = busy_q;
    stage_d = stage_q;
    tap_d   = tap_q;
    done_d  = 1'b0;
    if (abort) begin
      busy_d = 1'b0;
    end else if (accept) begin
      busy_d  = 1'b1;
      stage_d = 1'b0;
      tap_d   = '0;
    end else if (step) begin
      tap_d = tap_q + 3'd1;
    end else if (commit) begin
      tap_d = '0;
      if (stage_q) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end else begin
        stage_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q  <= 1'b0;
      stage_q <= 1'b0;
      tap_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      busy_q  <= busy_d;
      stage_q <= stage_d;
      tap_q   <= tap_d;
      done_q  <= done_d;
    end
  end

  assign stage = stage_q;
  assign tap   = tap_q;
  assign done  = done_q;
endmodule

// File: rtl/acm_mac.sv
module acm_mac #(
  parameter int CW   = 16,
  parameter int OW   = 14,
  parameter int ACCW = 33
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   zero,
  input  logic                   step,
  input  logic signed [CW-1:0]   coef,
  input  logic signed [OW-1:0]   opnd,
  output logic signed [ACCW-1:0] acc
);
  logic signed [CW+OW-1:0] prod;
  logic signed [ACCW-1:0]  prod_x;
  logic signed [ACCW-1:0]  acc_q, acc_d;

  always_comb begin
    prod   = coef * opnd;
    prod_x = prod;
    acc_d  = acc_q;
    if (zero)      acc_d = '0;
    else if (step) acc_d = acc_q + prod_x;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            acc_q <= '0;
    else if (zero || step) acc_q <= acc_d;
  end

  assign acc = acc_q;
endmodule

// File: rtl/acm_hist.sv
module acm_hist
  import avg_cm_pkg::*;
#(
  parameter int OW      = 14,
  parameter int ACCW    = 33,
  parameter int FRAC    = 10,
  parameter int YMIN    = 0,
  parameter int YMAX    = 2000,
  parameter bit HAS_PRE = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clr,
  input  logic                   pre,
  input  logic signed [OW-1:0]   pre_val,
  input  logic                   commit,
  input  logic signed [OW-1:0]   e_new,
  input  logic signed [ACCW-1:0] acc,
  output logic signed [OW-1:0]   e1,
  output logic signed [OW-1:0]   e2,
  output logic signed [OW-1:0]   u1,
  output logic signed [OW-1:0]   u2
);
  logic signed [63:0]   wide, lim;
  logic signed [OW-1:0] y;
  logic signed [OW-1:0] e1_d, e2_d, u1_d, u2_d;
  logic signed [OW-1:0] e1_q, e2_q, u1_q, u2_q;
  logic                 load_pre, wr;

  always_comb begin
    wide     = 64'(acc >>> FRAC);
    lim      = sat64(wide, longint'(YMIN), longint'(YMAX));
    y        = lim[OW-1:0];
    load_pre = HAS_PRE && pre;
    wr       = clr || load_pre || commit;
    e1_d = e1_q;
    e2_d = e2_q;
    u1_d = u1_q;
    u2_d = u2_q;
    if (clr) begin
      e1_d = '0;
      e2_d = '0;
      u1_d = '0;
      u2_d = '0;
    end else if (load_pre) begin
      u1_d = pre_val;
      u2_d = pre_val;
    end else if (commit) begin
      e1_d = e_new;
      e2_d = e1_q;
      u1_d = y;
      u2_d = u1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e1_q <= '0;
      e2_q <= '0;
      u1_q <= '0;
      u2_q <= '0;
    end else if (wr) begin
      e1_q <= e1_d;
      e2_q <= e2_d;
      u1_q <= u1_d;
      u2_q <= u2_d;
    end
  end

  assign e1 = e1_q;
  assign e2 = e2_q;
  assign u1 = u1_q;
  assign u2 = u2_q;
endmodule

// File: rtl/avg_cm_loop.sv
module avg_cm_loop #(
  parameter int DW   = 12,
  parameter int CW   = 16,
  parameter int FRAC = 10,
  parameter int B0_V = 3000,
  parameter int B1_V = -2800,
  parameter int B2_V = 0,
  parameter int A1_V = 1024,
  parameter int A2_V = 0,
  parameter int KP_V = 2048,
  parameter int VMIN = 0,
  parameter int VMAX = 2000,
  parameter int B0_I = 1500,
  parameter int B1_I = -1300,
  parameter int B2_I = 100,
  parameter int A1_I = 1536,
  parameter int A2_I = -512,
  parameter int KP_I = 1024,
  parameter int IMIN = 40,
  parameter int IMAX = 3900
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          trig,
  input  logic          clr,
  input  logic          pre,
  input  logic [DW-1:0] pre_val,
  input  logic          prop_mode,
  input  logic [DW-1:0] vref,
  input  logic [DW-1:0] vsamp,
  input  logic [DW-1:0] isamp,
  output logic          done,
  output logic [DW-1:0] duty,
  output logic [DW-1:0] cur_ref
);
  localparam int OW   = DW + 2;
  localparam int ACCW = CW + OW + 3;

  logic          accept, abort, step, commit, stage;
  logic [2:0]    tap;
  logic [DW-1:0] vref_q, vs_q, is_q;
  logic          prop_q;

  logic signed [OW-1:0]   e1_a [2];
  logic signed [OW-1:0]   e2_a [2];
  logic signed [OW-1:0]   u1_a [2];
  logic signed [OW-1:0]   u2_a [2];
  logic signed [OW-1:0]   e0, opnd, pre_w;
  logic signed [CW-1:0]   coef;
  logic signed [ACCW-1:0] acc;

  acm_seq u_seq (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .clr(clr), .pre(pre),
    .accept(accept), .abort(abort), .step(step), .commit(commit),
    .stage(stage), .tap(tap), .done(done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vref_q <= '0;
      vs_q   <= '0;
      is_q   <= '0;
      prop_q <= 1'b0;
    end else if (accept) begin
      vref_q <= vref;
      vs_q   <= vsamp;
      is_q   <= isamp;
      prop_q <= prop_mode;
    end
  end

  always_comb begin
    if (stage) e0 = u1_a[0] - $signed({2'b00, is_q});
    else       e0 = $signed({2'b00, vref_q}) - $signed({2'b00, vs_q});
    case (tap)
      3'd0:    opnd = e0;
      3'd1:    opnd = e1_a[stage];
      3'd2:    opnd = e2_a[stage];
      3'd3:    opnd = u1_a[stage];
      default: opnd = u2_a[stage];
    endcase
    if (prop_q) begin
      if (tap == 3'd0) coef = stage ? CW'(KP_I) : CW'(KP_V);
      else             coef = '0;
    end else begin
      case (tap)
        3'd0:    coef = stage ? CW'(B0_I) : CW'(B0_V);
        3'd1:    coef = stage ? CW'(B1_I) : CW'(B1_V);
        3'd2:    coef = stage ? CW'(B2_I) : CW'(B2_V);
        3'd3:    coef = stage ? CW'(A1_I) : CW'(A1_V);
        default: coef = stage ? CW'(A2_I) : CW'(A2_V);
      endcase
    end
    pre_w = $signed({2'b00, pre_val});
  end

  acm_mac #(.CW(CW), .OW(OW), .ACCW(ACCW)) u_mac (
    .clk(clk), .rst_n(rst_n), .zero(accept || commit || abort), .step(step),
    .coef(coef), .opnd(opnd), .acc(acc)
  );

  for (genvar g = 0; g < 2; g++) begin : g_stage
    acm_hist #(
      .OW(OW), .ACCW(ACCW), .FRAC(FRAC),
      .YMIN(g == 0 ? VMIN : IMIN), .YMAX(g == 0 ? VMAX : IMAX),
      .HAS_PRE(g == 1)
    ) u_hist (
      .clk(clk), .rst_n(rst_n), .clr(clr), .pre(pre), .pre_val(pre_w),
      .commit(commit && (stage == 1'(g))), .e_new(e0), .acc(acc),
      .e1(e1_a[g]), .e2(e2_a[g]), .u1(u1_a[g]), .u2(u2_a[g])
    );
  end

  assign duty    = u1_a[1][DW-1:0];
  assign cur_ref = u1_a[0][DW-1:0];
endmodule

// File: rtl/avg_cm_loop_chk.sv
module avg_cm_loop_chk #(
  parameter int DW   = 12,
  parameter int VMIN = 0,
  parameter int VMAX = 2000,
  parameter int IMIN = 40,
  parameter int IMAX = 3900
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic          clr,
  input logic          pre,
  input logic [DW-1:0] pre_val,
  input logic          done,
  input logic [DW-1:0] duty,
  input logic [DW-1:0] cur_ref
);
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_duty_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (int'(duty) >= IMIN && int'(duty) <= IMAX));

  p_ref_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_ref != $past(cur_ref)) && !$past(clr) |-> (int'(cur_ref) >= VMIN && int'(cur_ref) <= VMAX));

  p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !done);

  p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (duty == '0 && cur_ref == '0));

  p_preload_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pre && !clr |=> duty == $past(pre_val));

  p_duty_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !done && !$past(clr) && !$past(pre) |-> $stable(duty));
endmodule

bind avg_cm_loop avg_cm_loop_chk #(
  .DW(DW), .VMIN(VMIN), .VMAX(VMAX), .IMIN(IMIN), .IMAX(IMAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .clr(clr), .pre(pre), .pre_val(pre_val),
  .done(done), .duty(duty), .cur_ref(cur_ref)
);

// File: tb/avg_cm_loop_test.sv
module avg_cm_loop_test;
  localparam int DW = 12, FRAC = 10;
  localparam longint B0V = 3000, B1V = -2800, B2V = 0, A1V = 1024, A2V = 0, KPV = 2048;
  localparam longint VLO = 0, VHI = 2000;
  localparam longint B0I = 1500, B1I = -1300, B2I = 100, A1I = 1536, A2I = -512, KPI = 1024;
  localparam longint ILO = 40, IHI = 3900;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, trig = 1'b0, clr = 1'b0, pre = 1'b0, prop_mode = 1'b0;
  logic [DW-1:0] pre_val = '0, vref = '0, vsamp = '0, isamp = '0;
  logic done;
  logic [DW-1:0] duty, cur_ref;

  always #4 clk = ~clk;

  avg_cm_loop uut (
    .clk(clk), .rst_n(rst_n), .en(en), .trig(trig), .clr(clr), .pre(pre),
    .pre_val(pre_val), .prop_mode(prop_mode), .vref(vref), .vsamp(vsamp),
    .isamp(isamp), .done(done), .duty(duty), .cur_ref(cur_ref)
  );

  int n_cmp = 0, n_bad = 0, cyc = 0;
  string req = "R1";

  longint ve1, ve2, vu1, vu2, ie1, ie2, iu1, iu2;
  longint l_vr, l_vs, l_is;
  bit l_prop;
  int cnt;
  bit m_done;
  longint m_duty, m_ref;

  function automatic longint calc(longint e0, longint e1, longint e2, longint u1, longint u2,
                                  longint b0, longint b1, longint b2, longint a1, longint a2,
                                  longint kp, bit p, longint lo, longint hi);
    longint s;
    if (p) s = kp * e0;
    else   s = b0 * e0 + b1 * e1 + b2 * e2 + a1 * u1 + a2 * u2;
    s = s >>> FRAC;
    if (s > hi) s = hi;
    if (s < lo) s = lo;
    return s;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    longint e, y;
    if (!rst_n) begin
      ve1 = 0; ve2 = 0; vu1 = 0; vu2 = 0; ie1 = 0; ie2 = 0; iu1 = 0; iu2 = 0;
      cnt = 0; m_done = 0; m_duty = 0; m_ref = 0;
      l_vr = 0; l_vs = 0; l_is = 0; l_prop = 0;
    end else begin
      m_done = 0;
      if (clr) begin
        cnt = 0;
        ve1 = 0; ve2 = 0; vu1 = 0; vu2 = 0; ie1 = 0; ie2 = 0; iu1 = 0; iu2 = 0;
      end else if (pre) begin
        cnt = 0;
        iu1 = longint'(pre_val); iu2 = iu1;
      end else if (!en) begin
        cnt = 0;
      end else if (cnt == 0) begin
        if (trig) begin
          cnt = 12; l_vr = longint'(vref); l_vs = longint'(vsamp);
          l_is = longint'(isamp); l_prop = prop_mode;
        end
      end else begin
        cnt = cnt - 1;
        if (cnt == 6) begin
          e = l_vr - l_vs;
          y = calc(e, ve1, ve2, vu1, vu2, B0V, B1V, B2V, A1V, A2V, KPV, l_prop, VLO, VHI);
          ve2 = ve1; ve1 = e; vu2 = vu1; vu1 = y;
        end else if (cnt == 0) begin
          e = vu1 - l_is;
          y = calc(e, ie1, ie2, iu1, iu2, B0I, B1I, B2I, A1I, A2I, KPI, l_prop, ILO, IHI);
          ie2 = ie1; ie1 = e; iu2 = iu1; iu1 = y;
          m_done = 1;
        end
      end
      m_duty = iu1;
      m_ref  = vu1;
    end
  end

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      n_cmp++;
      if (done !== m_done || longint'(duty) != m_duty || longint'(cur_ref) != m_ref) begin
        n_bad++;
        $display("FAIL %s cycle %0d: done/duty/cur_ref actual %0b/%0d/%0d expected %0b/%0d/%0d",
                 req, cyc, done, duty, cur_ref, m_done, m_duty, m_ref);
      end
    end
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic fire(int vr, int vs, int is);
    @(negedge clk);
    vref = DW'(vr); vsamp = DW'(vs); isamp = DW'(is); trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    idle(3);
    // R1: reset values are compared while the block sits idle after reset
    req = "R1";
    @(negedge clk); rst_n = 1'b1;
    idle(4);
    en = 1'b1;
    // R2 R3: nominal updates with several error patterns, sampled at the result edges
    req = "R2/R3";
    fire(2048, 1900, 300);  idle(14);
    fire(2048, 2000, 500);  idle(14);
    fire(1500, 1600, 200);  idle(14);
    fire(2100, 2050, 900);  idle(14);
    // R4 R5: saturate both stages, then small errors expose the stored history
    req = "R4/R5";
    fire(4000, 0, 0);       idle(14);
    fire(4000, 0, 0);       idle(14);
    fire(2000, 1990, 100);  idle(14);
    fire(0, 4095, 4095);    idle(14);
    fire(1000, 1000, 4095); idle(14);
    fire(1000, 990, 10);    idle(14);
    // R6: triggers while busy and while disabled are dropped
    req = "R6";
    fire(2048, 1800, 400);
    idle(3); fire(100, 3000, 3000); idle(12);
    en = 1'b0; fire(3000, 100, 100); idle(14);
    en = 1'b1;
    // R7: enable drops in the middle of an update
    req = "R7";
    fire(2500, 1500, 600); idle(3);
    en = 1'b0; idle(3); en = 1'b1; idle(10);
    fire(2500, 1500, 600); idle(7);
    en = 1'b0; idle(2); en = 1'b1; idle(8);
    fire(2200, 2100, 700); idle(14);
    // R8: clear during an update and while idle, clear beats preload
    req = "R8";
    fire(2600, 1600, 800); idle(4);
    @(negedge clk); clr = 1'b1; pre = 1'b1; pre_val = 12'd1234;
    @(negedge clk); clr = 1'b0; pre = 1'b0;
    idle(12);
    fire(2300, 2200, 500); idle(14);
    // R9: preload then continue from the seeded duty
    req = "R9";
    @(negedge clk); pre = 1'b1; pre_val = 12'd1800;
    @(negedge clk); pre = 1'b0;
    idle(2);
    fire(2048, 2040, 1700); idle(14);
    fire(2048, 1500, 600); idle(8);
    @(negedge clk); pre = 1'b1; pre_val = 12'd777;
    @(negedge clk); pre = 1'b0;
    idle(12);
    // R10: proportional-only mode, then back to the compensators
    req = "R10";
    prop_mode = 1'b1;
    fire(2048, 1948, 150); idle(14);
    fire(2048, 2148, 50);  idle(14);
    fire(3000, 1000, 100); idle(14);
    prop_mode = 1'b0;
    fire(2048, 2000, 400); idle(14);
    // R11: long idle stretch, outputs must not move
    req = "R11";
    idle(40);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule